// File: doc/BRIEF.md
# On-die thermal readout monitor

The monitor takes raw signed readings from a set of on-die temperature sensors on a common sample strobe. Each reading is turned into an unsigned margin: the number of degrees below the maximum junction temperature. Readings that would lie above that limit are clamped to a margin of zero. Software can read each sensor's latest margin on its own, and can also read the smallest margin across all sensors, which is the hottest point at that instant.

A package value is derived from the hottest margin. It is averaged over a window of a power-of-two number of samples and updated once per window. The first sample after reset seeds it. A throttle request is raised from this averaged value against a programmable activation margin, and released with a small hysteresis.

Two programmable thresholds are compared with the instantaneous hottest margin. Crossings in each direction set sticky status bits. A separate out-of-spec bit is set from the instantaneous value, so that it is not hidden by the averaging. An interrupt request is raised from the status bits and a per-bit enable.

Top module: `thermal_monitor`

## Requirements
- R1: After a strobe, reading address 8+i returns the margin of sensor i from that strobe in bits [TW-1:0]; the upper bits read zero.
- R2: Each raw input is a (TW+1)-bit two's-complement value. A negative raw value reads back as margin 0, and a non-negative value reads back unchanged.
- R3: Address 6 returns the smallest margin of all sensors from the latest strobe.
- R4: Address 5 returns the package average. The first strobe after reset loads it with that strobe's hottest margin, and that sample counts as the first sample of the first window. After every further 2^AVG_SHIFT samples it is loaded with the floor of their sum shifted right by AVG_SHIFT. Before the first strobe it reads 0.
- R5: `throttle_o` is high one clock after the package average becomes less than or equal to the activation margin (address 0).
- R6: `throttle_o` goes low one clock after the average exceeds the activation margin plus HYST. When the average lies between those two points it keeps its value.
- R7: `throttle_o` stays low until the first strobe after reset has loaded the average.
- R8: Status bits (address 4) are set on crossings of the hottest margin. For threshold 0 (address 1), bit 0 is set by a heating crossing (previous margin above the threshold, new margin at or below it) and bit 1 by a cooling crossing (the reverse). Bits 2 and 3 do the same for threshold 1 (address 2). The first strobe after reset sets no crossing bit.
- R9: Status bit 4 (out-of-spec) is set by any strobe whose hottest margin is 0, whatever the average is.
- R10: Status bits stay set until software writes a one to them at address 4. A write of zero leaves a bit unchanged, and a set event in the same clock takes precedence over the clear.
- R11: `irq_o` is high exactly when some status bit is set and its enable bit at address 3 is also set.
- R12: The activation margin, both thresholds and the enable mask read back as written, and all of them reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe that marks valid sensor samples |
| smp_raw | input | N_SENS*(TW+1) | Packed raw signed readings, sensor 0 in the low bits |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| throttle_o | output | 1 | Throttle activation request |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong accumulator or sample count shows up on the average readback at the end of the window in which it happens, and on `throttle_o` one clock after that. An error in the stored previous hottest margin appears as a missing or extra crossing bit at the next strobe, and `irq_o` follows it in the same cycle. The bench drives a long pseudo-random sweep plus directed sequences around the activation point. After every strobe it compares every readback and both outputs with a model in the bench.

// File: rtl/thm_pkg.sv
package thm_pkg;
   localparam int unsigned ST_W       = 5;
   localparam int unsigned ST_T0_HEAT = 0;
   localparam int unsigned ST_T0_COOL = 1;
   localparam int unsigned ST_T1_HEAT = 2;
   localparam int unsigned ST_T1_COOL = 3;
   localparam int unsigned ST_OOS     = 4;
   localparam int unsigned N_THR      = 2;

   localparam int unsigned A_ACT    = 0;
   localparam int unsigned A_TH0    = 1;
   localparam int unsigned A_TH1    = 2;
   localparam int unsigned A_EN     = 3;
   localparam int unsigned A_STATUS = 4;
   localparam int unsigned A_AVG    = 5;
   localparam int unsigned A_HOT    = 6;
   localparam int unsigned A_SENS   = 8;
endpackage

// File: rtl/thm_sat.sv
module thm_sat #(
   parameter int unsigned TW = 7
) (
   input  logic [TW:0]   raw,
   output logic [TW-1:0] q
);
   // sign bit set means the sensor is beyond the limit: clamp to zero margin
   assign q = raw[TW] ? '0 : raw[TW-1:0];
endmodule

// File: rtl/thm_avg.sv
module thm_avg #(
   parameter int unsigned TW        = 7,
   parameter int unsigned AVG_SHIFT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stb,
   input  logic [TW-1:0] hot,
   output logic [TW-1:0] avg_q,
   output logic          avg_ok
);
   localparam int unsigned AW = TW + AVG_SHIFT;

   logic [AW-1:0]        acc_q;
   logic [AVG_SHIFT-1:0] cnt_q;
   logic [AW-1:0]        sum_w;

   assign sum_w = acc_q + AW'(hot);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         cnt_q  <= '0;
         avg_q  <= '0;
         avg_ok <= 1'b0;
      end else if (stb) begin
         if (!avg_ok) begin
            avg_q  <= hot;
            avg_ok <= 1'b1;
            acc_q  <= AW'(hot);
            cnt_q  <= AVG_SHIFT'(1);
         end else if (&cnt_q) begin
            avg_q <= TW'(sum_w >> AVG_SHIFT);
            acc_q <= '0;
            cnt_q <= '0;
         end else begin
            acc_q <= sum_w;
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/thm_xing.sv
module thm_xing #(
   parameter int unsigned TW = 7
) (
   input  logic          stb,
   input  logic          prev_ok,
   input  logic [TW-1:0] prev,
   input  logic [TW-1:0] cur,
   input  logic [TW-1:0] th,
   output logic          heat,
   output logic          cool
);
   logic live;
   assign live = stb && prev_ok;
   assign heat = live && (prev > th) && (cur <= th);
   assign cool = live && (prev <= th) && (cur > th);
endmodule

// File: rtl/thermal_monitor.sv
module thermal_monitor #(
   parameter int unsigned N_SENS    = 4,
   parameter int unsigned TW        = 7,
   parameter int unsigned AVG_SHIFT = 4,
   parameter int unsigned HYST      = 1,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DW        = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp_stb,
   input  logic [N_SENS*(TW+1)-1:0] smp_raw,
   input  logic                     reg_we,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [DW-1:0]            reg_wdata,
   output logic [DW-1:0]            reg_rdata,
   output logic                     throttle_o,
   output logic                     irq_o
);
   import thm_pkg::*;

   localparam int unsigned RW = TW + 1;

   if (N_SENS < 1 || N_SENS > 8) begin : g_bad_nsens
      $error("N_SENS must lie in 1..8");
   end
   if (AVG_SHIFT < 1) begin : g_bad_shift
      $error("AVG_SHIFT must be at least 1");
   end
   if (DW < TW || DW < ST_W || ADDR_W < 4) begin : g_bad_bus
      $error("register bus too narrow");
   end

   logic [TW-1:0]   sat_w  [N_SENS];
   logic [TW-1:0]   sens_q [N_SENS];
   logic [TW-1:0]   hot_new, hot_q;
   logic            hot_ok;
   logic [TW-1:0]   act_q;
   logic [TW-1:0]   th_q [N_THR];
   logic [ST_W-1:0] en_q, status_q, set_w, clr_w;
   logic [TW-1:0]   avg_q;
   logic            avg_ok;
   logic [N_THR-1:0] heat_w, cool_w;
   logic            st_wr;
   logic            unused_wdata;

   assign unused_wdata = ^reg_wdata;

   for (genvar g = 0; g < N_SENS; g++) begin : g_sens
      thm_sat #(.TW(TW)) u_sat (
         .raw (smp_raw[g*RW +: RW]),
         .q   (sat_w[g])
      );
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       sens_q[g] <= '0;
         else if (smp_stb) sens_q[g] <= sat_w[g];
      end
   end

   always_comb begin
      hot_new = sat_w[0];
      for (int i = 1; i < N_SENS; i++)
         if (sat_w[i] < hot_new) hot_new = sat_w[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hot_q  <= '0;
         hot_ok <= 1'b0;
      end else if (smp_stb) begin
         hot_q  <= hot_new;
         hot_ok <= 1'b1;
      end
   end

   thm_avg #(.TW(TW), .AVG_SHIFT(AVG_SHIFT)) u_avg (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (smp_stb),
      .hot    (hot_new),
      .avg_q  (avg_q),
      .avg_ok (avg_ok)
   );

   for (genvar t = 0; t < N_THR; t++) begin : g_thr
      thm_xing #(.TW(TW)) u_xing (
         .stb     (smp_stb),
         .prev_ok (hot_ok),
         .prev    (hot_q),
         .cur     (hot_new),
         .th      (th_q[t]),
         .heat    (heat_w[t]),
         .cool    (cool_w[t])
      );
   end

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
         th_q  <= '{default: '0};
         en_q  <= '0;
      end else if (reg_we) begin
         if (reg_addr == ADDR_W'(A_ACT)) act_q   <= reg_wdata[TW-1:0];
         if (reg_addr == ADDR_W'(A_TH0)) th_q[0] <= reg_wdata[TW-1:0];
         if (reg_addr == ADDR_W'(A_TH1)) th_q[1] <= reg_wdata[TW-1:0];
         if (reg_addr == ADDR_W'(A_EN))  en_q    <= reg_wdata[ST_W-1:0];
      end
   end

   // sticky status, write-one-to-clear, set wins
   assign st_wr = reg_we && (reg_addr == ADDR_W'(A_STATUS));
   assign clr_w = st_wr ? reg_wdata[ST_W-1:0] : '0;
   always_comb begin
      set_w              = '0;
      set_w[ST_T0_HEAT]  = heat_w[0];
      set_w[ST_T0_COOL]  = cool_w[0];
      set_w[ST_T1_HEAT]  = heat_w[1];
      set_w[ST_T1_COOL]  = cool_w[1];
      set_w[ST_OOS]      = smp_stb && (hot_new == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (status_q & ~clr_w) | set_w;
   end

   assign irq_o = |(status_q & en_q);

   // throttle with hysteresis on the averaged margin
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  throttle_o <= 1'b0;
      else if (!avg_ok)            throttle_o <= 1'b0;
      else if (avg_q <= act_q)     throttle_o <= 1'b1;
      else if ({1'b0, avg_q} > {1'b0, act_q} + RW'(HYST))
                                   throttle_o <= 1'b0;
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(A_ACT):    reg_rdata[TW-1:0]   = act_q;
         ADDR_W'(A_TH0):    reg_rdata[TW-1:0]   = th_q[0];
         ADDR_W'(A_TH1):    reg_rdata[TW-1:0]   = th_q[1];
         ADDR_W'(A_EN):     reg_rdata[ST_W-1:0] = en_q;
         ADDR_W'(A_STATUS): reg_rdata[ST_W-1:0] = status_q;
         ADDR_W'(A_AVG):    reg_rdata[TW-1:0]   = avg_q;
         ADDR_W'(A_HOT):    reg_rdata[TW-1:0]   = hot_q;
         default: begin
            for (int i = 0; i < N_SENS; i++)
               if (reg_addr == ADDR_W'(A_SENS + i)) reg_rdata[TW-1:0] = sens_q[i];
         end
      endcase
   end
endmodule

// File: rtl/thm_checker.sv
module thm_checker #(
   parameter int unsigned TW   = 7,
   parameter int unsigned HYST = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          smp_stb,
   input logic [TW-1:0] hot_new,
   input logic [TW-1:0] avg_q,
   input logic [TW-1:0] act_q,
   input logic          avg_ok,
   input logic          throttle_o,
   input logic [4:0]    status_q,
   input logic          st_wr
);
   p_thr_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (avg_ok && avg_q <= act_q) |=> throttle_o);

   p_thr_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (avg_ok && ({1'b0, avg_q} > {1'b0, act_q} + (TW+1)'(HYST))) |=> !throttle_o);

   p_thr_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !avg_ok |-> !throttle_o);

   p_oos_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && hot_new == '0) |=> status_q[4]);

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !st_wr |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

bind thermal_monitor thm_checker #(.TW(TW), .HYST(HYST)) i_thm_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_stb    (smp_stb),
   .hot_new    (hot_new),
   .avg_q      (avg_q),
   .act_q      (act_q),
   .avg_ok     (avg_ok),
   .throttle_o (throttle_o),
   .status_q   (status_q),
   .st_wr      (st_wr)
);

// File: tb/test_thermal_monitor.sv
module test_thermal_monitor;
   localparam int NS = 4;
   localparam int TW = 7;
   localparam int SH = 2;
   localparam int HY = 1;
   localparam int RW = TW + 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             smp_stb = 1'b0;
   logic [NS*RW-1:0] smp_raw = '0;
   logic             reg_we = 1'b0;
   logic [3:0]       reg_addr = '0;
   logic [15:0]      reg_wdata = '0;
   logic [15:0]      reg_rdata;
   logic             throttle_o, irq_o;

   int total = 0, bad = 0;
   // bench model
   int m_sens[NS];
   int m_hot = 0, m_prev = 0, m_prev_ok = 0;
   int m_avg = 0, m_avg_ok = 0, m_sum = 0, m_cnt = 0;
   int m_act = 0, m_th0 = 0, m_th1 = 0, m_en = 0, m_st = 0, m_thr = 0;
   logic [15:0] lfsr = 16'hACE1;

   thermal_monitor #(.N_SENS(NS), .TW(TW), .AVG_SHIFT(SH), .HYST(HY)) i_thermal_monitor (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_raw(smp_raw),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .throttle_o(throttle_o), .irq_o(irq_o));

   always #10 clk = ~clk;

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk);
      reg_addr = 4'(a);
      #1 v = int'(reg_rdata);
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_addr = 4'(a); reg_wdata = 16'(d); reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
      @(negedge clk);
   endtask

   function automatic void model_thr();
      if (m_avg_ok != 0) begin
         if (m_avg <= m_act) m_thr = 1;
         else if (m_avg > m_act + HY) m_thr = 0;
      end
   endfunction

   task automatic sample(input int r0, input int r1, input int r2, input int r3);
      int raws[NS];
      raws[0] = r0; raws[1] = r1; raws[2] = r2; raws[3] = r3;
      @(negedge clk);
      for (int i = 0; i < NS; i++) smp_raw[i*RW +: RW] = RW'(raws[i]);
      smp_stb = 1'b1;
      @(negedge clk);
      smp_stb = 1'b0;
      @(negedge clk);
      // model
      m_hot = 1000;
      for (int i = 0; i < NS; i++) begin
         m_sens[i] = (raws[i] < 0) ? 0 : raws[i];
         if (m_sens[i] < m_hot) m_hot = m_sens[i];
      end
      if (m_prev_ok != 0) begin
         if (m_prev > m_th0 && m_hot <= m_th0) m_st |= 1;
         if (m_prev <= m_th0 && m_hot > m_th0) m_st |= 2;
         if (m_prev > m_th1 && m_hot <= m_th1) m_st |= 4;
         if (m_prev <= m_th1 && m_hot > m_th1) m_st |= 8;
      end
      if (m_hot == 0) m_st |= 16;
      m_prev = m_hot; m_prev_ok = 1;
      if (m_avg_ok == 0) begin
         m_avg = m_hot; m_avg_ok = 1; m_sum = m_hot; m_cnt = 1;
      end else begin
         m_sum += m_hot; m_cnt++;
         if (m_cnt == (1 << SH)) begin
            m_avg = m_sum >> SH; m_sum = 0; m_cnt = 0;
         end
      end
      model_thr();
   endtask

   task automatic check_all();
      int v;
      for (int i = 0; i < NS; i++) begin
         rd(8 + i, v); check("R1/R2 sensor margin", v, m_sens[i]);
      end
      rd(6, v); check("R3 hottest", v, m_hot);
      rd(5, v); check("R4 package average", v, m_avg);
      rd(4, v); check("R8/R9 status", v, m_st);
      check("R5/R6 throttle", int'(throttle_o), m_thr);
      check("R11 irq", int'(irq_o), ((m_st & m_en) != 0) ? 1 : 0);
   endtask

   function automatic int rnd_raw();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return int'(lfsr % 16'd45) - 4;
   endfunction

   initial begin
      #4_000_000;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int v;
      for (int i = 0; i < NS; i++) m_sens[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check("R7 throttle after reset", int'(throttle_o), 0);
      check("R11 irq after reset", int'(irq_o), 0);
      rd(4, v); check("R10 status after reset", v, 0);
      rd(5, v); check("R4 average before first sample", v, 0);
      for (int a = 0; a < 4; a++) begin
         rd(a, v); check("R12 config reset value", v, 0);
      end
      // idle cycles with no strobe keep throttle low
      repeat (5) @(negedge clk);
      check("R7 throttle idle before sample", int'(throttle_o), 0);

      wr(0, 3);  m_act = 3; model_thr();
      wr(1, 12); m_th0 = 12;
      wr(2, 6);  m_th1 = 6;
      wr(3, 0);  m_en = 0;
      rd(0, v); check("R12 act readback", v, 3);
      rd(1, v); check("R12 th0 readback", v, 12);
      rd(2, v); check("R12 th1 readback", v, 6);

      // seed from first sample, no crossing on first sample
      sample(20, 25, 22, 40); check_all();
      // saturation of negatives, passthrough of maximum positive
      sample(-3, 9, 127, -128); check_all();
      sample(15, 15, 15, 15); check_all();
      sample(8, 9, 10, 11); check_all();
      // drive to throttle: window of zeros
      for (int k = 0; k < 4; k++) begin sample(0, 0, 0, 0); check_all(); end
      // hold window at act+1 (R6 hysteresis)
      for (int k = 0; k < 4; k++) begin sample(4, 4, 4, 4); check_all(); end
      check("R6 hold at act+1", int'(throttle_o), 1);
      // release window at act+2
      for (int k = 0; k < 4; k++) begin sample(5, 6, 7, 5); check_all(); end
      check("R6 release above act+HYST", int'(throttle_o), 0);
      // act raise puts average under activation point
      wr(0, 5); m_act = 5; model_thr();
      check("R5 throttle after act write", int'(throttle_o), 1);
      wr(0, 3); m_act = 3; model_thr();

      // W1C partial clear, write zero no effect
      rd(4, v); check("R10 status before clear", v, m_st);
      wr(4, 0);
      rd(4, v); check("R10 zero write keeps status", v, m_st);
      wr(4, 1); m_st &= ~1;
      rd(4, v); check("R10 w1c bit 0", v, m_st);
      wr(3, 16); m_en = 16;
      check("R11 irq from oos enable", int'(irq_o), ((m_st & 16) != 0) ? 1 : 0);
      wr(4, 31); m_st = 0;
      check("R11 irq after full clear", int'(irq_o), 0);

      // pseudo-random sweep
      for (int k = 0; k < 300; k++) begin
         sample(rnd_raw(), rnd_raw(), rnd_raw(), rnd_raw());
         check_all();
         if (k % 37 == 36) begin
            int mask;
            mask = int'(lfsr[4:0]);
            wr(4, mask); m_st &= ~mask;
            wr(3, int'(lfsr[9:5])); m_en = int'(lfsr[9:5]);
            rd(4, v); check("R10 status after w1c", v, m_st);
            check("R11 irq after enable change", int'(irq_o), ((m_st & m_en) != 0) ? 1 : 0);
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule